// File: doc/BRIEF.md
# Wide-to-Narrow Bus Transaction Splitter

This block sits between a processor-side master with a 64-bit data path and a slave bus that moves 32 bits per data phase. It takes one processor request at a time and turns it into the narrow transfers that carry it. Each transfer has a word-aligned address and byte enables. For reads it steers each returned word onto the matching half of the 64-bit data bus. For writes it picks the matching half of the processor write data onto the narrow write bus.

A request that touches only one 32-bit word becomes one narrow transfer. A request whose bytes fall on both sides of the 32-bit boundary becomes two transfers: the low word first, then the high word, each with its own address phase. A cache-line request becomes a single burst grant followed by eight one-word data phases. On a line read, a strobe marks each delivered word and gives its index. On a line write, a beat index tells the processor which doubleword to present.

Address-only cycles are acknowledged locally and never reach the narrow bus. An error reported by the slave on any data phase ends the sequence at once, and the error is reported with the acknowledge.

Top module: `wide_narrow_splitter`

## Requirements
- R1: A request with `cpu_addr_only` set raises `cpu_ack` in the cycle after acceptance, and `nb_req` stays low for the whole request.
- R2: A single access whose bytes lie only in the low word (address bit 2 = 0) issues one transfer at address `{cpu_addr[31:3],3'b000}`. Read data appears on `cpu_rdata[31:0]`, write data is taken from `cpu_wdata[31:0]`, and the upper half of `cpu_rdata` reads zero.
- R3: A single access whose bytes lie only in the high word issues one transfer at `{cpu_addr[31:3],3'b100}`. Read data appears on `cpu_rdata[63:32]`, and `nb_wdata` carries `cpu_wdata[63:32]` on the one narrow lane.
- R4: An access with bytes in both words issues exactly two transfers, the low-word address first and then the high-word address. Each one has its own request and grant, and `nb_addr`/`nb_be` stay stable while a request waits for `nb_gnt`.
- R5: In a split write, the first data phase drives `cpu_wdata[31:0]` and the second drives `cpu_wdata[63:32]`.
- R6: Byte enables come from `cpu_addr[2:0]` and `cpu_size` (1..8 bytes, start offset plus size at most 8). The doubleword mask is `((1<<size)-1)<<offset`, and bit i of `nb_be` enables byte lane `nb_wdata[8i+7:8i]`. The low-word transfer carries mask bits 3:0 and the high-word transfer carries mask bits 7:4, so the halves of a split never overlap.
- R7: A line request issues one grant with `nb_burst` high, all-ones byte enables and an address aligned to 32 bytes, followed by eight data phases. During phase k, `nb_addr` equals the line base plus 4k, `cpu_wbeat` equals k, and `nb_wdata` is taken from `cpu_wdata[63:32]` when k is odd and from `cpu_wdata[31:0]` when k is even.
- R8: On a line read, each completed phase k produces one `cpu_rvalid` pulse in the following cycle, with `cpu_rword` = k (in ascending order). The word sits on `cpu_rdata[63:32]` for odd k and on `cpu_rdata[31:0]` for even k.
- R9: Every request gets exactly one one-cycle `cpu_ack`. For a transferring request, the acknowledge comes only after its last narrow data phase.
- R10: A data phase completed with `nb_err` high ends the request. No further transfer is issued (a pending high word is dropped, and no further burst phases occur), and `cpu_err` is high with `cpu_ack`.
- R11: `cpu_req` is sampled only while the block is idle. A request raised while a transfer is in progress produces no acknowledge and changes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, sampled when idle |
| cpu_addr_only | input | 1 | Request carries no data |
| cpu_line | input | 1 | Request is a 32-byte line transfer |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_size | input | 4 | Bytes in a single access, 1..8 |
| cpu_wdata | input | 64 | Write data, held until acknowledge; follows `cpu_wbeat` on line writes |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Slave error, valid with `cpu_ack` |
| cpu_rdata | output | 64 | Steered read data |
| cpu_rvalid | output | 1 | Line-read word strobe |
| cpu_rword | output | 3 | Index of the word marked by `cpu_rvalid` |
| cpu_wbeat | output | 3 | Current line beat index |
| nb_req | output | 1 | Narrow bus address-phase request |
| nb_wr | output | 1 | Narrow transfer direction |
| nb_burst | output | 1 | Transfer is an eight-phase line burst |
| nb_addr | output | 32 | Word-aligned narrow address |
| nb_be | output | 4 | Byte enables |
| nb_wdata | output | 32 | Narrow write data |
| nb_gnt | input | 1 | Address phase accepted |
| nb_rdy | input | 1 | Data phase complete |
| nb_err | input | 1 | Data phase ended in error |
| nb_rdata | input | 32 | Narrow read data |

## Verification
Several properties are checked on every cycle: the acknowledge lasts one cycle, a request holds its address and enables until granted, a burst address is line-aligned, enables are never empty, an address-only cycle is acknowledged with no narrow request, read strobes occur only on reads, and an error phase leads straight to the acknowledge. Other behaviour needs whole scenarios driven by a slave model with random grant and ready delays. That covers the order and count of split transfers, the data in each lane, the index order of the burst strobes, the dropping of the high word after an error, and ignoring a request raised mid-transfer.

// File: rtl/wns_pkg.sv
package wns_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ_W0  = 3'd1,
        ST_DATA_W0 = 3'd2,
        ST_REQ_W1  = 3'd3,
        ST_DATA_W1 = 3'd4,
        ST_BURST   = 3'd5,
        ST_ACK     = 3'd6
    } wns_state_e;
endpackage

// File: rtl/wns_be_gen.sv
module wns_be_gen #(
    parameter int BE_W   = 4,
    parameter int OFF_W  = 3,
    parameter int SIZE_W = 4
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [SIZE_W-1:0] size,
    output logic [BE_W-1:0]   be_lo,
    output logic [BE_W-1:0]   be_hi
);
    localparam int MW = 4 * BE_W;

    logic [MW-1:0] ones;
    logic [MW-1:0] mask;

    always_comb begin
        ones  = (MW'(1) << size) - MW'(1);
        mask  = ones << offset;
        be_lo = mask[BE_W-1:0];
        be_hi = mask[2*BE_W-1:BE_W];
    end
endmodule

// File: rtl/wns_lane_pick.sv
module wns_lane_pick #(
    parameter int NW = 32
) (
    input  logic [2*NW-1:0] wide,
    input  logic            sel_hi,
    output logic [NW-1:0]   narrow
);
    always_comb begin
        narrow = sel_hi ? wide[2*NW-1:NW] : wide[NW-1:0];
    end
endmodule

// File: rtl/wide_narrow_splitter.sv
module wide_narrow_splitter
    import wns_pkg::*;
#(
    parameter  int AW         = 32,
    parameter  int NW         = 32,
    parameter  int LINE_WORDS = 8,
    localparam int BE_W       = NW / 8,
    localparam int WIDE_W     = 2 * NW,
    localparam int WOFF       = $clog2(BE_W),
    localparam int OFF_W      = WOFF + 1,
    localparam int SIZE_W     = OFF_W + 1,
    localparam int BEAT_W     = $clog2(LINE_WORDS),
    localparam int LINE_OFF   = BEAT_W + WOFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_addr_only,
    input  logic              cpu_line,
    input  logic              cpu_wr,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [SIZE_W-1:0] cpu_size,
    input  logic [WIDE_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic              cpu_err,
    output logic [WIDE_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic [BEAT_W-1:0] cpu_rword,
    output logic [BEAT_W-1:0] cpu_wbeat,
    output logic              nb_req,
    output logic              nb_wr,
    output logic              nb_burst,
    output logic [AW-1:0]     nb_addr,
    output logic [BE_W-1:0]   nb_be,
    output logic [NW-1:0]     nb_wdata,
    input  logic              nb_gnt,
    input  logic              nb_rdy,
    input  logic              nb_err,
    input  logic [NW-1:0]     nb_rdata
);
    typedef struct packed {
        wns_state_e        st;
        logic [AW-1:0]     addr;
        logic              line;
        logic              wr;
        logic              hi;
        logic [BE_W-1:0]   be_lo;
        logic [BE_W-1:0]   be_hi;
        logic [BEAT_W-1:0] beat;
        logic [WIDE_W-1:0] rdata;
        logic              rvalid;
        logic [BEAT_W-1:0] rword;
        logic              err;
    } ctl_t;

    ctl_t q, d;

    logic [BE_W-1:0] be_lo_w, be_hi_w;
    logic            lane_hi;

    wns_be_gen #(.BE_W(BE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) be_gen_i (
        .offset (cpu_addr[OFF_W-1:0]),
        .size   (cpu_size),
        .be_lo  (be_lo_w),
        .be_hi  (be_hi_w)
    );

    assign lane_hi = q.line ? q.beat[0] : q.hi;

    wns_lane_pick #(.NW(NW)) lane_i (
        .wide   (cpu_wdata),
        .sel_hi (lane_hi),
        .narrow (nb_wdata)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.addr  = cpu_addr;
                    d.line  = cpu_line;
                    d.wr    = cpu_wr;
                    d.be_lo = be_lo_w;
                    d.be_hi = be_hi_w;
                    d.beat  = '0;
                    d.rdata = '0;
                    d.err   = 1'b0;
                    d.hi    = !cpu_line && (be_lo_w == '0);
                    d.st    = cpu_addr_only ? ST_ACK : ST_REQ_W0;
                end
            end
            ST_REQ_W0: begin
                if (nb_gnt) d.st = q.line ? ST_BURST : ST_DATA_W0;
            end
            ST_DATA_W0: begin
                if (nb_rdy) begin
                    if (!q.wr) begin
                        if (q.hi) d.rdata[WIDE_W-1:NW] = nb_rdata;
                        else      d.rdata[NW-1:0]      = nb_rdata;
                    end
                    if (nb_err) begin
                        d.err = 1'b1;
                        d.st  = ST_ACK;
                    end else if (!q.hi && (q.be_hi != '0)) begin
                        d.hi = 1'b1;
                        d.st = ST_REQ_W1;
                    end else begin
                        d.st = ST_ACK;
                    end
                end
            end
            ST_REQ_W1: begin
                if (nb_gnt) d.st = ST_DATA_W1;
            end
            ST_DATA_W1: begin
                if (nb_rdy) begin
                    if (!q.wr) d.rdata[WIDE_W-1:NW] = nb_rdata;
                    d.err = nb_err;
                    d.st  = ST_ACK;
                end
            end
            ST_BURST: begin
                if (nb_rdy) begin
                    if (nb_err) begin
                        d.err = 1'b1;
                        d.st  = ST_ACK;
                    end else begin
                        if (!q.wr) begin
                            if (q.beat[0]) d.rdata[WIDE_W-1:NW] = nb_rdata;
                            else           d.rdata[NW-1:0]      = nb_rdata;
                            d.rvalid = 1'b1;
                            d.rword  = q.beat;
                        end
                        if (q.beat == BEAT_W'(LINE_WORDS - 1)) d.st = ST_ACK;
                        else                                   d.beat = q.beat + 1'b1;
                    end
                end
            end
            ST_ACK:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        nb_req     = (q.st == ST_REQ_W0) || (q.st == ST_REQ_W1);
        nb_wr      = q.wr;
        nb_burst   = q.line;
        nb_be      = q.line ? {BE_W{1'b1}} : (q.hi ? q.be_hi : q.be_lo);
        nb_addr    = q.line ? {q.addr[AW-1:LINE_OFF], q.beat, {WOFF{1'b0}}}
                            : {q.addr[AW-1:OFF_W], q.hi, {WOFF{1'b0}}};
        cpu_ack    = (q.st == ST_ACK);
        cpu_err    = q.err;
        cpu_rdata  = q.rdata;
        cpu_rvalid = q.rvalid;
        cpu_rword  = q.rword;
        cpu_wbeat  = q.beat;
    end

    AST_ADDR_ONLY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && cpu_req && cpu_addr_only) |=> (cpu_ack && !nb_req)); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_req && !nb_gnt) |=> (nb_req && $stable(nb_addr) && $stable(nb_be))); // R4
    AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        nb_req |-> (nb_be != '0)); // R6
    AST_BURST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_req && nb_burst) |-> (nb_addr[LINE_OFF-1:0] == '0)); // R7
    AST_RVALID_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> !nb_wr); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R9
    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_DATA_W0 || q.st == ST_BURST) && nb_rdy && nb_err) |=> (cpu_ack && cpu_err && !nb_req)); // R10
endmodule

// File: tb/wide_narrow_splitter_tb_top.sv
module wide_narrow_splitter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_addr_only, cpu_line, cpu_wr;
    logic [31:0] cpu_addr;
    logic [3:0]  cpu_size;
    logic [63:0] cpu_wdata;
    logic        cpu_ack, cpu_err, cpu_rvalid;
    logic [63:0] cpu_rdata;
    logic [2:0]  cpu_rword, cpu_wbeat;
    logic        nb_req, nb_wr, nb_burst;
    logic [31:0] nb_addr, nb_wdata, nb_rdata;
    logic [3:0]  nb_be;
    logic        nb_gnt, nb_rdy, nb_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_narrow_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr_only(cpu_addr_only), .cpu_line(cpu_line),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .cpu_rword(cpu_rword), .cpu_wbeat(cpu_wbeat),
        .nb_req(nb_req), .nb_wr(nb_wr), .nb_burst(nb_burst), .nb_addr(nb_addr),
        .nb_be(nb_be), .nb_wdata(nb_wdata),
        .nb_gnt(nb_gnt), .nb_rdy(nb_rdy), .nb_err(nb_err), .nb_rdata(nb_rdata)
    );

    function automatic logic [31:0] rpat(logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
    endfunction

    function automatic logic [7:0] bmask(logic [2:0] off, logic [3:0] sz);
        logic [15:0] m;
        m = ((16'd1 << sz) - 16'd1) << off;
        return m[7:0];
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(bit ao, bit ln, bit wr, logic [31:0] addr, logic [3:0] sz,
                           int err_at, bit poke);
        logic [7:0]  mask;
        logic [31:0] lw [8];
        logic [63:0] wd, got_rd, exp_rd;
        logic [31:0] base, half;
        bit          ex_hi [2];
        int          ex_n, exp_n, phases, xi, phase, left, rv, cyc, ack_cyc;
        bit          in_data, got, got_err, exp_err;
        string       tag;

        mask = bmask(addr[2:0], sz);
        base = {addr[31:5], 5'b0};
        for (int k = 0; k < 8; k++) lw[k] = $urandom;
        wd = {$urandom, $urandom};
        ex_n = 0;
        if (!ao && !ln) begin
            if (mask[3:0] != 4'h0) begin ex_hi[ex_n] = 1'b0; ex_n++; end
            if (mask[7:4] != 4'h0) begin ex_hi[ex_n] = 1'b1; ex_n++; end
        end
        phases  = ao ? 0 : (ln ? 8 : ex_n);
        exp_n   = ao ? 0 : (ln ? 1 : ((err_at == 0) ? 1 : ex_n));
        exp_err = (err_at >= 0) && (err_at < phases);
        tag = (ex_n == 2) ? "R4" : ((ex_n == 1 && ex_hi[0]) ? "R3" : "R2");

        cpu_req = 1'b1; cpu_addr_only = ao; cpu_line = ln; cpu_wr = wr;
        cpu_addr = addr; cpu_size = sz;
        cpu_wdata = ln ? {lw[1], lw[0]} : wd;
        @(negedge clk);
        cpu_req = 1'b0; cpu_addr_only = 1'b0;

        xi = 0; phase = 0; left = 0; rv = 0; cyc = 0; ack_cyc = -1;
        in_data = 1'b0; got = 1'b0; got_err = 1'b0; got_rd = '0;
        while (!got && cyc < 400) begin
            if (ln && wr) begin
                cpu_wdata = {lw[cpu_wbeat | 3'd1], lw[cpu_wbeat & 3'd6]};
                #1;
            end
            if (cpu_rvalid) begin
                chk(rv < 8 && cpu_rword == rv[2:0], "R8", "strobe word index", 64'(cpu_rword), 64'(rv));
                half = cpu_rword[0] ? cpu_rdata[63:32] : cpu_rdata[31:0];
                chk(half == rpat(base + 32'(cpu_rword) * 4), "R8", "strobe data lane",
                    64'(half), 64'(rpat(base + 32'(cpu_rword) * 4)));
                rv++;
            end
            if (cpu_ack) begin
                got = 1'b1; ack_cyc = cyc; got_err = cpu_err; got_rd = cpu_rdata;
            end else if (nb_req && !in_data) begin
                if ($urandom % 2 == 0) begin
                    nb_gnt = 1'b1;
                    chk(!ao, "R1", "narrow request on address-only", 64'(nb_req), 64'd0);
                    if (xi < exp_n) begin
                        if (ln) begin
                            chk(nb_addr == base && nb_burst, "R7", "burst address/flag", 64'(nb_addr), 64'(base));
                            chk(nb_be == 4'hF, "R7", "burst enables", 64'(nb_be), 64'hF);
                        end else begin
                            chk(nb_addr == {addr[31:3], ex_hi[xi], 2'b00} && !nb_burst, tag, "transfer address",
                                64'(nb_addr), 64'({addr[31:3], ex_hi[xi], 2'b00}));
                            chk(nb_be == (ex_hi[xi] ? mask[7:4] : mask[3:0]), "R6", "byte enables",
                                64'(nb_be), 64'(ex_hi[xi] ? mask[7:4] : mask[3:0]));
                        end
                        chk(nb_wr == wr, tag, "direction", 64'(nb_wr), 64'(wr));
                    end else begin
                        chk(1'b0, (err_at >= 0) ? "R10" : "R4", "extra narrow transfer", 64'(xi), 64'(exp_n));
                    end
                    in_data = 1'b1; left = ln ? 8 : 1; xi++;
                end
            end else if (in_data && ($urandom % 2 == 0)) begin
                nb_rdy = 1'b1;
                nb_rdata = rpat(nb_addr);
                nb_err = (phase == err_at);
                if (ln) begin
                    chk(nb_addr == base + 32'(8 - left) * 4 && cpu_wbeat == 3'(8 - left), "R7", "beat address",
                        64'(nb_addr), 64'(base + 32'(8 - left) * 4));
                    if (wr) chk(nb_wdata == lw[8 - left], "R7", "burst write lane", 64'(nb_wdata), 64'(lw[8 - left]));
                end else if (wr) begin
                    chk(nb_wdata == (ex_hi[xi-1] ? wd[63:32] : wd[31:0]),
                        (ex_n == 2) ? "R5" : (ex_hi[xi-1] ? "R3" : "R2"), "write lane",
                        64'(nb_wdata), 64'(ex_hi[xi-1] ? wd[63:32] : wd[31:0]));
                end
                phase++; left--;
                if (left == 0 || nb_err) in_data = 1'b0;
            end
            if (poke && cyc == 1) begin cpu_req = 1'b1; cpu_addr_only = 1'b1; end
            @(negedge clk);
            nb_gnt = 1'b0; nb_rdy = 1'b0; nb_err = 1'b0;
            cpu_req = 1'b0; cpu_addr_only = 1'b0;
            cyc++;
        end

        chk(got, "R9", "acknowledge seen", 64'(got), 64'd1);
        if (ao) chk(ack_cyc == 0, "R1", "address-only ack latency", 64'(ack_cyc), 64'd0);
        chk(xi == exp_n, ao ? "R1" : (exp_err ? "R10" : tag), "transfer count", 64'(xi), 64'(exp_n));
        chk(got_err == exp_err, "R10", "error flag with ack", 64'(got_err), 64'(exp_err));
        if (!ao && !exp_err) chk(phase == phases, "R9", "phases before ack", 64'(phase), 64'(phases));
        if (ln && !wr) chk(rv == (exp_err ? err_at : 8), "R8", "strobe count", 64'(rv), 64'(exp_err ? err_at : 8));
        else           chk(rv == 0, "R8", "no strobe outside line read", 64'(rv), 64'd0);
        if (!ao && !ln && !wr && !exp_err) begin
            exp_rd[31:0]  = (mask[3:0] != 4'h0) ? rpat({addr[31:3], 3'b000}) : 32'h0;
            exp_rd[63:32] = (mask[7:4] != 4'h0) ? rpat({addr[31:3], 3'b100}) : 32'h0;
            chk(got_rd == exp_rd, tag, "read data steering", got_rd, exp_rd);
        end
        chk(!cpu_ack, "R9", "ack is one cycle", 64'(cpu_ack), 64'd0);
        if (poke) begin
            @(negedge clk);
            chk(!cpu_ack && !nb_req, "R11", "busy request ignored", 64'({cpu_ack, nb_req}), 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog expired act=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] off;
        logic [3:0] sz;
        int         sel, ea;
        void'($urandom(32'h5EED_0017));
        rst_n = 1'b0; cpu_req = 1'b0; cpu_addr_only = 1'b0; cpu_line = 1'b0; cpu_wr = 1'b0;
        cpu_addr = '0; cpu_size = 4'd1; cpu_wdata = '0;
        nb_gnt = 1'b0; nb_rdy = 1'b0; nb_err = 1'b0; nb_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!nb_req && !cpu_ack && !cpu_rvalid, "R9", "reset state", 64'({nb_req, cpu_ack, cpu_rvalid}), 64'd0);

        run_txn(1, 0, 0, 32'h0000_1000, 4'd1, -1, 0);   // R1
        run_txn(0, 0, 0, 32'h0000_2000, 4'd4, -1, 0);   // R2 word 0 read
        run_txn(0, 0, 0, 32'h0000_2004, 4'd4, -1, 0);   // R3 word 1 read
        run_txn(0, 0, 1, 32'h0000_2005, 4'd2, -1, 0);   // R3 word 1 write lane copy
        run_txn(0, 0, 1, 32'h0000_3002, 4'd4, -1, 0);   // R4 R5 split write
        run_txn(0, 0, 0, 32'h0000_3003, 4'd2, -1, 0);   // R4 R6 split read
        run_txn(0, 0, 0, 32'h0000_3000, 4'd8, -1, 0);   // R6 full doubleword
        run_txn(0, 1, 0, 32'h0000_4000, 4'd8, -1, 0);   // R7 R8 line read
        run_txn(0, 1, 1, 32'h0000_4060, 4'd8, -1, 0);   // R7 line write
        run_txn(0, 0, 0, 32'h0000_5001, 4'd6, 0, 0);    // R10 error drops word 1
        run_txn(0, 1, 0, 32'h0000_5020, 4'd8, 3, 0);    // R10 error mid burst
        run_txn(0, 0, 1, 32'h0000_6002, 4'd4, -1, 1);   // R11 busy request
        run_txn(0, 1, 1, 32'h0000_6040, 4'd8, -1, 1);   // R11 busy during burst

        for (int t = 0; t < 300; t++) begin
            sel = int'($urandom % 20);
            off = 3'($urandom);
            sz  = 4'(1 + ($urandom % (8 - off)));
            ea  = ($urandom % 10 == 0) ? int'($urandom % 9) : -1;
            if (sel == 0)
                run_txn(1, 0, 1'($urandom), {$urandom} & 32'hFFFF_FFF8, 4'd1, -1, 0);
            else if (sel < 4)
                run_txn(0, 1, 1'($urandom), $urandom, 4'd8, ea, 1'($urandom));
            else
                run_txn(0, 0, 1'($urandom), {$urandom} & 32'hFFFF_FFF8 | 32'(off), sz, ea, 1'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule